// File: doc/BRIEF.md
# Oscillator Pitch Auto-Tune Tracker

This block keeps the tuning of an analog oscillator honest while it plays. It is told which note is sounding, and for how many reference clocks one cycle of that note should last. That expected period already has the octave shift, pitch bend and detune folded in. It times the real oscillator by counting reference clocks between rising edges of the oscillator's square wave. The difference between measured and expected period is summed over fixed windows of cycles, and each window is reduced to one average by an arithmetic shift.

Nothing changes while the note is held. When the matching note-off arrives, the average of the most recent complete window is clamped to a bounded step. That step is added to the tuning word stored for that note. A note that sounded too briefly leaves its entry alone. The block holds one tuning word per note number. It always presents the word of the most recently started note, which is what a DAC driving the oscillator would use.

Top module: `osc_autotune`

## Requirements
- R1: After reset every note's tuning word is 16'h8000, and the word shown for any freshly started note before any release is 16'h8000.
- R2: While no note-on or note-off pulse is present, `tune_word` does not change, even after complete measurement windows have been taken during the held note.
- R3: On a note-off whose number equals the sounding note, the entry grows by the average error of the last complete window of 16 periods. The error of one period is the measured clock count minus `tgt_period`, and the average is the window sum shifted right arithmetically by 4 (rounding toward minus infinity). Repeated notes accumulate.
- R4: If fewer than 16 valid periods were measured since the note started, its note-off leaves the entry unchanged.
- R5: Each applied correction is limited to the range -64 to +64.
- R6: A note-off whose number differs from the sounding note has no effect, and the sounding note keeps being tracked.
- R7: A note-on arriving while a note sounds discards everything measured for the old note, which is then never updated by that performance.
- R8: The first synchronized rising edge after a note-on only starts timing, so the idle time before the oscillator's first edge never counts as a period.
- R9: A period that reaches the counter's all-ones value (4095 clocks by default) is discarded and adds nothing to the average.
- R10: A note-on makes `tune_word` show the stored word of the new note from the next cycle on. Each note number has its own independent entry.
- R11: When several windows completed during one note, only the last complete window's average is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, also used to time oscillator periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Square output of the oscillator, asynchronous to clk |
| note_on | input | 1 | One-cycle pulse that starts the note in `note_num` |
| note_off | input | 1 | One-cycle pulse that releases the note in `note_num` |
| note_num | input | 7 | Note number that goes with a note-on or note-off pulse |
| tgt_period | input | 12 | Expected period in clocks, offsets already applied |
| tune_word | output | 16 | Tuning word of the most recently started note |

## Verification
The checker assumes that `tgt_period` stays constant while a note sounds. It also assumes that note pulses last exactly one cycle, and that a pulse on `note_on` and one on `note_off` never coincide. The bench drives every input on the falling clock edge and changes `tgt_period` only between notes. It leaves several idle cycles after the last oscillator edge before releasing, so that the final measured period has settled into the average. Oscillator periods are kept within the counter range, except in the one scenario built to show that an over-long period is dropped.

// File: rtl/atun_pkg.sv
`timescale 1ns/1ps
package atun_pkg;

   // State of the period meter: idle until the first edge arms it.
   typedef enum logic {
      MT_IDLE = 1'b0,
      MT_RUN  = 1'b1
   } meter_st_t;

   // Smallest synchronizer depth that still settles metastability.
   localparam int MIN_SYNC = 2;

endpackage

// File: rtl/atun_edge_sync.sv
`timescale 1ns/1ps
module atun_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   // stg[STAGES-1] is the synchronized level, stg[STAGES] its history.
   logic [STAGES:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-1:0], async_in};
   end

   assign rise = stg[STAGES-1] & ~stg[STAGES];
endmodule

// File: rtl/atun_period_meter.sv
`timescale 1ns/1ps
module atun_period_meter
   import atun_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             rise,
   output logic             per_valid,
   output logic [CNT_W-1:0] per_val
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   meter_st_t        st;
   logic [CNT_W-1:0] cnt;
   logic             counting;

   assign counting = (st == MT_RUN) && (cnt != CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= MT_IDLE;
         cnt       <= '0;
         per_valid <= 1'b0;
         per_val   <= '0;
      end else begin
         per_valid <= 1'b0;
         if (clear) begin
            st  <= MT_IDLE;
            cnt <= '0;
         end else if (rise) begin
            // A saturated count means the period overflowed: drop it.
            if (counting) begin
               per_valid <= 1'b1;
               per_val   <= cnt;
            end
            st  <= MT_RUN;
            cnt <= CNT_ONE;
         end else if (counting) begin
            cnt <= cnt + CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/atun_err_avg.sv
`timescale 1ns/1ps
module atun_err_avg #(
   parameter int CNT_W     = 12,
   parameter int AVG_LOG2  = 4,
   parameter int ROUND_AVG = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    per_valid,
   input  logic [CNT_W-1:0]        per_val,
   input  logic [CNT_W-1:0]        tgt,
   output logic signed [CNT_W:0]   avg_err,
   output logic                    avg_ok
);
   localparam int EW = CNT_W + 1;
   localparam int SW = EW + AVG_LOG2 + 1;

   logic signed [EW-1:0]     err;
   logic signed [SW-1:0]     sum;
   logic signed [SW-1:0]     sum_nx;
   logic signed [SW-1:0]     quo;
   logic [AVG_LOG2-1:0]      n_seen;
   logic                     last_in_win;

   assign err         = $signed({1'b0, per_val}) - $signed({1'b0, tgt});
   assign sum_nx      = sum + SW'(err);
   assign last_in_win = &n_seen;

   generate
      if (ROUND_AVG != 0) begin : g_round
         localparam logic signed [SW-1:0] HALF = SW'(1 << (AVG_LOG2 - 1));
         assign quo = (sum_nx + HALF) >>> AVG_LOG2;
      end else begin : g_floor
         assign quo = sum_nx >>> AVG_LOG2;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum     <= '0;
         n_seen  <= '0;
         avg_err <= '0;
         avg_ok  <= 1'b0;
      end else if (clear) begin
         sum     <= '0;
         n_seen  <= '0;
         avg_ok  <= 1'b0;
      end else if (per_valid) begin
         if (last_in_win) begin
            sum     <= '0;
            n_seen  <= '0;
            avg_err <= EW'(quo);
            avg_ok  <= 1'b1;
         end else begin
            sum     <= sum_nx;
            n_seen  <= n_seen + 1'b1;
         end
      end
   end
endmodule

// File: rtl/atun_tune_table.sv
`timescale 1ns/1ps
module atun_tune_table #(
   parameter int          NOTE_W    = 7,
   parameter int          WORD_W    = 16,
   parameter int          CORR_W    = 13,
   parameter int          STEP_MAX  = 64,
   parameter int unsigned INIT_WORD = 32'h8000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [NOTE_W-1:0]        wr_note,
   input  logic signed [CORR_W-1:0] corr,
   input  logic [NOTE_W-1:0]        rd_note,
   output logic [WORD_W-1:0]        rd_word
);
   localparam int NOTES = 1 << NOTE_W;
   localparam int SUM_W = WORD_W + 2;
   localparam logic signed [CORR_W-1:0] POS_LIM = CORR_W'(STEP_MAX);
   localparam logic signed [CORR_W-1:0] NEG_LIM = -POS_LIM;
   localparam logic signed [SUM_W-1:0]  TOP     = {2'b00, {WORD_W{1'b1}}};
   localparam logic [WORD_W-1:0]        RST_VAL = WORD_W'(INIT_WORD);

   logic [WORD_W-1:0]        entry [NOTES];
   logic signed [CORR_W-1:0] step;
   logic signed [SUM_W-1:0]  base;
   logic signed [SUM_W-1:0]  nxt_raw;
   logic [WORD_W-1:0]        nxt_word;

   always_comb begin
      if (corr > POS_LIM)      step = POS_LIM;
      else if (corr < NEG_LIM) step = NEG_LIM;
      else                     step = corr;
   end

   always_comb begin
      base    = $signed({2'b00, entry[wr_note]});
      nxt_raw = base + SUM_W'(step);
      if (nxt_raw[SUM_W-1])  nxt_word = '0;
      else if (nxt_raw > TOP) nxt_word = '1;
      else                    nxt_word = nxt_raw[WORD_W-1:0];
   end

   generate
      for (genvar g = 0; g < NOTES; g++) begin : g_entry
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= RST_VAL;
            else if (wr_en && (wr_note == NOTE_W'(g)))   q <= nxt_word;
         end
         assign entry[g] = q;
      end
   endgenerate

   assign rd_word = entry[rd_note];
endmodule

// File: rtl/osc_autotune.sv
`timescale 1ns/1ps
module osc_autotune
   import atun_pkg::*;
#(
   parameter int          NOTE_W      = 7,
   parameter int          WORD_W      = 16,
   parameter int          CNT_W       = 12,
   parameter int          AVG_LOG2    = 4,
   parameter int          STEP_MAX    = 64,
   parameter int          SYNC_STAGES = 2,
   parameter int          ROUND_AVG   = 0,
   parameter int unsigned INIT_WORD   = 32'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_in,
   input  logic              note_on,
   input  logic              note_off,
   input  logic [NOTE_W-1:0] note_num,
   input  logic [CNT_W-1:0]  tgt_period,
   output logic [WORD_W-1:0] tune_word
);
   localparam int ERR_W = CNT_W + 1;

   generate
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("osc_autotune: SYNC_STAGES below minimum");
      end
      if (AVG_LOG2 < 1 || AVG_LOG2 > 10) begin : g_bad_avg
         $error("osc_autotune: AVG_LOG2 out of range");
      end
      if (STEP_MAX < 1 || STEP_MAX >= (1 << CNT_W)) begin : g_bad_step
         $error("osc_autotune: STEP_MAX does not fit the error width");
      end
      if (WORD_W + 2 < ERR_W) begin : g_bad_word
         $error("osc_autotune: WORD_W too narrow for the correction");
      end
   endgenerate

   logic                    active;
   logic [NOTE_W-1:0]       cur_note;
   logic                    off_hit;
   logic                    rise;
   logic                    per_valid;
   logic [CNT_W-1:0]        per_val;
   logic signed [ERR_W-1:0] avg_err;
   logic                    avg_ok;
   logic                    wr_en;
   logic                    meter_clr;

   // Note tracking: a note-on always wins over a simultaneous note-off.
   assign off_hit   = note_off && !note_on && active && (note_num == cur_note);
   assign meter_clr = note_on || !active;
   assign wr_en     = off_hit && avg_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur_note <= '0;
      end else if (note_on) begin
         active   <= 1'b1;
         cur_note <= note_num;
      end else if (off_hit) begin
         active   <= 1'b0;
      end
   end

   atun_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (osc_in),
      .rise     (rise)
   );

   atun_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (meter_clr),
      .rise      (rise),
      .per_valid (per_valid),
      .per_val   (per_val)
   );

   atun_err_avg #(
      .CNT_W     (CNT_W),
      .AVG_LOG2  (AVG_LOG2),
      .ROUND_AVG (ROUND_AVG)
   ) u_avg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (note_on),
      .per_valid (per_valid),
      .per_val   (per_val),
      .tgt       (tgt_period),
      .avg_err   (avg_err),
      .avg_ok    (avg_ok)
   );

   atun_tune_table #(
      .NOTE_W    (NOTE_W),
      .WORD_W    (WORD_W),
      .CORR_W    (ERR_W),
      .STEP_MAX  (STEP_MAX),
      .INIT_WORD (INIT_WORD)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_note (cur_note),
      .corr    (avg_err),
      .rd_note (cur_note),
      .rd_word (tune_word)
   );
endmodule

// File: rtl/osc_autotune_chk.sv
`timescale 1ns/1ps
module osc_autotune_chk #(
   parameter int NOTE_W   = 7,
   parameter int WORD_W   = 16,
   parameter int CNT_W    = 12,
   parameter int STEP_MAX = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              note_on,
   input logic              note_off,
   input logic [NOTE_W-1:0] note_num,
   input logic [WORD_W-1:0] tune_word,
   input logic              active,
   input logic [NOTE_W-1:0] cur_note,
   input logic              per_valid,
   input logic [CNT_W-1:0]  per_val
);
   // R2: without any note pulse the presented word holds.
   a_r2_word_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!note_on && !note_off) |=> $stable(tune_word));

   // R6: a release naming another note leaves the word alone.
   a_r6_foreign_off: assert property (@(posedge clk) disable iff (!rst_n)
      (note_off && !note_on && active && note_num != cur_note) |=> $stable(tune_word));

   // R5: a matching release moves the word by at most the step limit.
   a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (note_off && !note_on && active && note_num == cur_note) |=>
      ((int'(tune_word) - int'($past(tune_word)) <= STEP_MAX) &&
       (int'(tune_word) - int'($past(tune_word)) >= -STEP_MAX)));

   // R3: a matching release ends the note.
   a_r3_off_ends_note: assert property (@(posedge clk) disable iff (!rst_n)
      (note_off && !note_on && active && note_num == cur_note) |=> !active);

   // R10: a note-on selects the new note.
   a_r10_on_selects: assert property (@(posedge clk) disable iff (!rst_n)
      note_on |=> (active && cur_note == $past(note_num)));

   // R9: no overflowed or empty period reaches the averager.
   a_r9_no_sat_period: assert property (@(posedge clk) disable iff (!rst_n)
      per_valid |-> (per_val != '1 && per_val != '0));
endmodule

bind osc_autotune osc_autotune_chk #(
   .NOTE_W   (NOTE_W),
   .WORD_W   (WORD_W),
   .CNT_W    (CNT_W),
   .STEP_MAX (STEP_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .note_on   (note_on),
   .note_off  (note_off),
   .note_num  (note_num),
   .tune_word (tune_word),
   .active    (active),
   .cur_note  (cur_note),
   .per_valid (per_valid),
   .per_val   (per_val)
);

// File: tb/osc_autotune_tb_top.sv
`timescale 1ns/1ps
module osc_autotune_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        osc_in;
   logic        note_on;
   logic        note_off;
   logic [6:0]  note_num;
   logic [11:0] tgt_period;
   logic [15:0] tune_word;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   osc_autotune dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_in     (osc_in),
      .note_on    (note_on),
      .note_off   (note_off),
      .note_num   (note_num),
      .tgt_period (tgt_period),
      .tune_word  (tune_word)
   );

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     mon_ev;

   // Driver side: queue the expected word, then wake the monitor.
   task automatic expect_word(input logic [15:0] exp, input string tag);
      sb_item_t it;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      ->mon_ev;
      #1;
   endtask

   // Monitor side: pop and compare against the output.
   initial begin
      forever begin
         sb_item_t it;
         @(mon_ev);
         while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_chk++;
            if (tune_word !== it.exp) begin
               n_bad++;
               $display("FAIL %s: tune_word actual=%h expected=%h", it.tag, tune_word, it.exp);
            end
         end
      end
   end

   task automatic idle(input int c);
      repeat (c) @(negedge clk);
   endtask

   task automatic press(input logic [6:0] n);
      @(negedge clk);
      note_on  = 1'b1;
      note_num = n;
      @(negedge clk);
      note_on  = 1'b0;
   endtask

   task automatic release_note(input logic [6:0] n);
      @(negedge clk);
      note_off = 1'b1;
      note_num = n;
      @(negedge clk);
      note_off = 1'b0;
      idle(1);
   endtask

   // cnt rising edges, each followed by per clocks until the next one.
   task automatic osc_run(input int cnt, input int per);
      for (int i = 0; i < cnt; i++) begin
         osc_in = 1'b1;
         repeat (per / 2) @(negedge clk);
         osc_in = 1'b0;
         repeat (per - per / 2) @(negedge clk);
      end
   endtask

   initial begin
      #3_000_000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n      = 1'b0;
      osc_in     = 1'b0;
      note_on    = 1'b0;
      note_off   = 1'b0;
      note_num   = '0;
      tgt_period = 12'd50;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1: reset contents, also R4 with no periods at all.
      press(7'd5);
      expect_word(16'h8000, "R1 note 5 after reset");
      release_note(7'd5);
      expect_word(16'h8000, "R4 release without periods");
      press(7'd127);
      expect_word(16'h8000, "R1 note 127 after reset");
      release_note(7'd127);

      // R3 with R2: 19 periods of 53 vs 50 -> +3 on release only.
      tgt_period = 12'd50;
      press(7'd10);
      osc_run(20, 53);
      idle(5);
      expect_word(16'h8000, "R2 held note unchanged");
      release_note(7'd10);
      expect_word(16'h8003, "R3 plus three");

      // R10: other entries independent.
      press(7'd11);
      expect_word(16'h8000, "R10 neighbour untouched");
      release_note(7'd11);

      // R3 floor: errors -5,-2 alternate, sum -56 -> -4.
      tgt_period = 12'd60;
      press(7'd20);
      for (int k = 0; k < 17; k++) osc_run(1, (k % 2 == 0) ? 55 : 58);
      idle(5);
      release_note(7'd20);
      expect_word(16'h7FFC, "R3 negative floor");

      // R5: clamp both signs.
      tgt_period = 12'd100;
      press(7'd30);
      osc_run(20, 200);
      idle(5);
      release_note(7'd30);
      expect_word(16'h8040, "R5 positive clamp");
      tgt_period = 12'd200;
      press(7'd31);
      osc_run(20, 40);
      idle(5);
      release_note(7'd31);
      expect_word(16'h7FC0, "R5 negative clamp");

      // R4: 15 periods only.
      tgt_period = 12'd50;
      press(7'd40);
      osc_run(16, 52);
      idle(5);
      release_note(7'd40);
      expect_word(16'h8000, "R4 short note");

      // R6: foreign release ignored, real one applies +4.
      press(7'd50);
      osc_run(20, 54);
      idle(5);
      release_note(7'd51);
      expect_word(16'h8000, "R6 foreign release");
      release_note(7'd50);
      expect_word(16'h8004, "R6 matching release after foreign");

      // R7: retrigger discards the old note's data.
      press(7'd60);
      osc_run(20, 52);
      idle(5);
      press(7'd61);
      expect_word(16'h8000, "R7 new note shown");
      release_note(7'd61);
      expect_word(16'h8000, "R7 stale average not applied");
      press(7'd60);
      expect_word(16'h8000, "R7 old note untouched");
      release_note(7'd60);
      expect_word(16'h8000, "R7 old note still untouched");

      // R8: long gap before first edge; 16 periods of 45 -> -5.
      press(7'd70);
      idle(300);
      osc_run(17, 45);
      idle(5);
      release_note(7'd70);
      expect_word(16'h7FFB, "R8 first edge only arms");

      // R9: one 5000-clock period dropped, then 16 of 56 -> +6.
      press(7'd80);
      osc_run(1, 5000);
      osc_run(17, 56);
      idle(5);
      release_note(7'd80);
      expect_word(16'h8006, "R9 overflowed period dropped");

      // R11: window 1 = 16x60, window 2 = 60 + 15x47 -> sum -35 -> -3.
      press(7'd90);
      osc_run(17, 60);
      osc_run(16, 47);
      idle(5);
      expect_word(16'h8000, "R2 two windows held");
      release_note(7'd90);
      expect_word(16'h7FFD, "R11 last window applied");

      // R10 and R3: replay note 10, shows stored word, then accumulates.
      press(7'd10);
      expect_word(16'h8003, "R10 stored word shown");
      osc_run(20, 53);
      idle(5);
      release_note(7'd10);
      expect_word(16'h8006, "R3 accumulates over notes");

      idle(5);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule